// File: doc/BRIEF.md
# Aging Forwarding Table with Load-Use Stall

This block feeds operands to the execute stage of an in-order pipeline. It keeps a small shared table of recently produced results and does not compare against every pipeline register. At the start of each execute cycle the two source operands read from the register file are looked up in the table. A newer value found there replaces the stale register-file value. At the end of the cycle, the result of the instruction that leaves execute is pushed into the table. Each entry carries an age. Once the age reaches a fixed limit the entry drops out, so nothing ever has to remove entries explicitly.

A load does not know its value while it is in execute. The block therefore records the load's destination in a one-cycle stall register and inserts a pending table entry. If the next instruction in execute reads that register, the block raises a stall, and the instruction stays in the decode-to-execute FIFO for one cycle. On its retry, the operand comes straight from the memory-response data. The pending entry captures that data at the same time, so later readers can use it.

A pipeline flush squashes the instruction in execute and clears the stall register. Entries already in the table come from older instructions and are kept. Register 0 is never forwarded and never causes a stall.

Top module: `agefwd_unit`

## Requirements
- R1: After reset the table holds no valid entry and no load is recorded. Each operand output equals its register-file input, and `ex_stall` is 0.
- R2: An instruction fires when `ex_valid`=1, `ex_stall`=0 and `flush`=0. A firing instruction with `ex_wr_en`=1, `ex_is_load`=0 and `ex_rd`≠0 has its `ex_result` forwarded to any source equal to `ex_rd` in each of the 1st, 2nd and 3rd cycles after it fires. From the 4th cycle on, the register-file value is used.
- R3: When several valid entries match one source register, the value of the most recently fired instruction is forwarded.
- R4: Register 0 is never written into the table and never forwarded: a source address of 0 always yields its register-file input. A load to register 0 never causes a stall.
- R5: A load is an instruction with `ex_wr_en`=1 and `ex_is_load`=1. In the cycle right after a load to register r≠0 fires, `ex_stall` is 1 in the same cycle if `ex_valid`=1, `flush`=0 and either source address equals r.
- R6: A load stall lasts exactly one cycle. Two cycles after the load fires, a source equal to r yields `mem_ld_data` of that cycle. That value is then forwarded in the following cycle (the load's last cycle of life) whatever `mem_ld_data` does, unless a younger write to r overrides it.
- R7: An instruction that does not fire (stalled, invalid or flushed) writes nothing into the table.
- R8: `flush` forces `ex_stall` to 0, and it clears the recorded load so that there is no stall in the following cycle. Table entries written before the flush keep being forwarded, and that includes a pending load, which still takes its memory data.
- R9: A source with no matching valid entry yields its register-file input.
- R10: `ex_stall` is 0 whenever `ex_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Squash the instruction in execute and clear the load record |
| ex_valid | input | 1 | An instruction is present in execute |
| ex_rs1 | input | 5 | First source register address |
| ex_rs2 | input | 5 | Second source register address |
| ex_rf1 | input | 32 | Register-file value for the first source |
| ex_rf2 | input | 32 | Register-file value for the second source |
| ex_wr_en | input | 1 | The instruction writes a destination register |
| ex_is_load | input | 1 | The instruction is a load (its value arrives later) |
| ex_rd | input | 5 | Destination register address |
| ex_result | input | 32 | Execute result for non-load instructions |
| mem_ld_data | input | 32 | Load data from the memory-response stage |
| ex_op1 | output | 32 | Resolved first operand |
| ex_op2 | output | 32 | Resolved second operand |
| ex_stall | output | 1 | Hold the instruction in execute for this cycle |

## Verification
The operand outputs and `ex_stall` are combinational within the execute cycle. The bench drives each cycle's inputs on the falling edge and samples the outputs one time unit later, before the rising edge that commits the table update. A write made on one rising edge is due in the next sampled cycle and stays visible for exactly three sampled cycles. A load's stall is due in the first cycle after it fires, and its memory data is due in the second. The behavioural queue model is advanced on the same rising edge as the design, so every cycle is compared against the window each requirement states.

// File: rtl/agefwd_pkg.sv
package agefwd_pkg;

    localparam int XLEN        = 32;
    localparam int REG_AW      = 5;
    localparam int FWD_DEPTH   = 4;
    localparam int AGE_LIMIT   = 3;
    localparam int AGE_W       = $clog2(AGE_LIMIT + 1);
    localparam int LD_DATA_AGE = 1;   // age at which load data is on mem_ld_data
    localparam int NUM_SRC     = 2;

    typedef logic [REG_AW-1:0] reg_addr_t;
    typedef logic [XLEN-1:0]   word_t;
    typedef logic [AGE_W-1:0]  age_t;

    typedef struct packed {
        logic      valid;
        logic      pend;    // load result not yet captured
        reg_addr_t addr;
        word_t     data;
        age_t      age;
    } fwd_entry_t;

    typedef struct packed {
        logic      valid;
        reg_addr_t rd;
    } ld_mark_t;

    // Advance one entry by a cycle: capture load data, age, expire.
    function automatic fwd_entry_t age_entry(fwd_entry_t e, word_t ld_data);
        fwd_entry_t n;
        n = e;
        if (e.valid) begin
            if (e.pend && (e.age == age_t'(LD_DATA_AGE))) begin
                n.data = ld_data;
                n.pend = 1'b0;
            end
            n.age = e.age + age_t'(1);
            if (n.age >= age_t'(AGE_LIMIT)) begin
                n.valid = 1'b0;
                n.pend  = 1'b0;
            end
        end
        return n;
    endfunction

    function automatic logic addr_hit(fwd_entry_t e, reg_addr_t rs);
        return e.valid && (rs != '0) && (e.addr == rs);
    endfunction

endpackage

// File: rtl/agefwd_table.sv
module agefwd_table
    import agefwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  fwd_entry_t wr_entry,
    input  word_t      ld_data,
    output fwd_entry_t ent_o [FWD_DEPTH]
);

    fwd_entry_t ent_q [FWD_DEPTH];

    // Slot 0 is always the youngest; a write shifts older entries down.
    for (genvar g = 0; g < FWD_DEPTH; g++) begin : g_slot
        fwd_entry_t next_e;

        if (g == 0) begin : g_head
            assign next_e = wr_en ? wr_entry : age_entry(ent_q[0], ld_data);
        end else begin : g_tail
            assign next_e = wr_en ? age_entry(ent_q[g-1], ld_data)
                                  : age_entry(ent_q[g], ld_data);
        end

        always_ff @(posedge clk) begin
            if (rst) ent_q[g] <= '0;
            else     ent_q[g] <= next_e;
        end

        AST_ENTRY_LIFE: assert property (@(posedge clk) disable iff (rst)
            ent_q[g].valid |-> (ent_q[g].age < age_t'(AGE_LIMIT)))
            else $error("entry outlived its age limit"); // R2

        AST_PEND_BOUND: assert property (@(posedge clk) disable iff (rst)
            ent_q[g].pend |-> (ent_q[g].valid && ent_q[g].age <= age_t'(LD_DATA_AGE)))
            else $error("pending load entry not resolved in time"); // R6
    end

    assign ent_o = ent_q;

endmodule

// File: rtl/agefwd_lookup.sv
module agefwd_lookup
    import agefwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fwd_entry_t ent [FWD_DEPTH],
    input  reg_addr_t  rs,
    input  word_t      rf_val,
    input  word_t      ld_data,
    output word_t      op
);

    // Scan oldest to youngest so the youngest match is applied last.
    always_comb begin
        op = rf_val;
        for (int i = FWD_DEPTH - 1; i >= 0; i--) begin
            if (addr_hit(ent[i], rs)) begin
                op = ent[i].pend ? ld_data : ent[i].data;
            end
        end
    end

    AST_R0_PASS: assert property (@(posedge clk) disable iff (rst)
        (rs == '0) |-> (op == rf_val))
        else $error("register 0 was forwarded"); // R4

endmodule

// File: rtl/agefwd_hazard.sv
module agefwd_hazard
    import agefwd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      flush,
    input  logic      ld_fire,
    input  reg_addr_t ld_rd,
    input  logic      ex_valid,
    input  reg_addr_t rs1,
    input  reg_addr_t rs2,
    output logic      stall
);

    ld_mark_t mark_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            mark_q <= '0;
        end else begin
            mark_q.valid <= ld_fire && (ld_rd != '0);
            mark_q.rd    <= ld_rd;
        end
    end

    assign stall = ex_valid && !flush && mark_q.valid &&
                   ((rs1 == mark_q.rd) || (rs2 == mark_q.rd));

    AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        stall |=> !stall)
        else $error("load stall lasted more than one cycle"); // R6

    AST_FLUSH_DROP: assert property (@(posedge clk) disable iff (rst)
        flush |=> !stall)
        else $error("stall survived a flush"); // R8

    AST_STALL_NONZERO: assert property (@(posedge clk) disable iff (rst)
        stall |-> ((rs1 != '0) || (rs2 != '0)))
        else $error("stall raised for register 0 only"); // R4

endmodule

// File: rtl/agefwd_unit.sv
module agefwd_unit
    import agefwd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  flush,
    input  logic                  ex_valid,
    input  logic [REG_AW-1:0]     ex_rs1,
    input  logic [REG_AW-1:0]     ex_rs2,
    input  logic [XLEN-1:0]       ex_rf1,
    input  logic [XLEN-1:0]       ex_rf2,
    input  logic                  ex_wr_en,
    input  logic                  ex_is_load,
    input  logic [REG_AW-1:0]     ex_rd,
    input  logic [XLEN-1:0]       ex_result,
    input  logic [XLEN-1:0]       mem_ld_data,
    output logic [XLEN-1:0]       ex_op1,
    output logic [XLEN-1:0]       ex_op2,
    output logic                  ex_stall
);

    logic       fire;
    logic       tbl_wr;
    logic       ld_fire;
    fwd_entry_t new_entry;
    fwd_entry_t ent [FWD_DEPTH];

    reg_addr_t  src_rs [NUM_SRC];
    word_t      src_rf [NUM_SRC];
    word_t      src_op [NUM_SRC];

    assign fire    = ex_valid && !ex_stall && !flush;
    assign tbl_wr  = fire && ex_wr_en && (ex_rd != '0);
    assign ld_fire = fire && ex_wr_en && ex_is_load;

    always_comb begin
        new_entry       = '0;
        new_entry.valid = 1'b1;
        new_entry.pend  = ex_is_load;
        new_entry.addr  = ex_rd;
        new_entry.data  = ex_is_load ? '0 : ex_result;
        new_entry.age   = '0;
    end

    agefwd_table u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (tbl_wr),
        .wr_entry (new_entry),
        .ld_data  (mem_ld_data),
        .ent_o    (ent)
    );

    assign src_rs[0] = ex_rs1;
    assign src_rs[1] = ex_rs2;
    assign src_rf[0] = ex_rf1;
    assign src_rf[1] = ex_rf2;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        agefwd_lookup u_lookup (
            .clk     (clk),
            .rst     (rst),
            .ent     (ent),
            .rs      (src_rs[g]),
            .rf_val  (src_rf[g]),
            .ld_data (mem_ld_data),
            .op      (src_op[g])
        );
    end

    assign ex_op1 = src_op[0];
    assign ex_op2 = src_op[1];

    agefwd_hazard u_hazard (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .ld_fire  (ld_fire),
        .ld_rd    (ex_rd),
        .ex_valid (ex_valid),
        .rs1      (ex_rs1),
        .rs2      (ex_rs2),
        .stall    (ex_stall)
    );

    AST_STALL_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        !ex_valid |-> !ex_stall)
        else $error("stall without an instruction"); // R10

endmodule

// File: tb/tb_agefwd_unit.sv
module tb_agefwd_unit;
    import agefwd_pkg::*;

    localparam time CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic        rst, flush, ex_valid, ex_wr_en, ex_is_load, ex_stall;
    logic [4:0]  ex_rs1, ex_rs2, ex_rd;
    logic [31:0] ex_rf1, ex_rf2, ex_result, mem_ld_data, ex_op1, ex_op2;

    agefwd_unit dut (
        .clk(clk), .rst(rst), .flush(flush), .ex_valid(ex_valid),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rf1(ex_rf1), .ex_rf2(ex_rf2),
        .ex_wr_en(ex_wr_en), .ex_is_load(ex_is_load), .ex_rd(ex_rd),
        .ex_result(ex_result), .mem_ld_data(mem_ld_data),
        .ex_op1(ex_op1), .ex_op2(ex_op2), .ex_stall(ex_stall)
    );

    typedef struct {
        int          age;
        bit          pend;
        int          rd;
        logic [31:0] data;
    } ment_t;

    ment_t mq[$];          // youngest first
    bit    m_lv;
    int    m_lrd;
    int    n_checks = 0;
    int    n_fail   = 0;

    function automatic logic [31:0] m_op(int rs, logic [31:0] rf, logic [31:0] mem);
        if (rs == 0) return rf;
        foreach (mq[i]) if (mq[i].rd == rs) return mq[i].pend ? mem : mq[i].data;
        return rf;
    endfunction

    task automatic step(string tag, bit v, int rs1, int rs2, bit wr, bit ld,
                        int rd, logic [31:0] res, logic [31:0] mem, bit fl);
        logic [31:0] e1, e2, rf1, rf2;
        bit          es, fire;
        ment_t       nq[$];
        @(negedge clk);
        rf1 = 32'hF000_0000 | rs1;
        rf2 = 32'hE000_0000 | rs2;
        ex_valid = v; ex_rs1 = 5'(rs1); ex_rs2 = 5'(rs2);
        ex_rf1 = rf1; ex_rf2 = rf2; ex_wr_en = wr; ex_is_load = ld;
        ex_rd = 5'(rd); ex_result = res; mem_ld_data = mem; flush = fl;
        #1;
        es = v && !fl && m_lv && (rs1 == m_lrd || rs2 == m_lrd);
        e1 = m_op(rs1, rf1, mem);
        e2 = m_op(rs2, rf2, mem);
        n_checks++;
        if (ex_op1 !== e1 || ex_op2 !== e2 || ex_stall !== es) begin
            n_fail++;
            $display("FAIL %s: op1=%h exp %h, op2=%h exp %h, stall=%b exp %b",
                     tag, ex_op1, e1, ex_op2, e2, ex_stall, es);
        end
        fire = v && !es && !fl;
        @(posedge clk);
        foreach (mq[i]) begin
            ment_t e = mq[i];
            if (e.pend && e.age == 1) begin e.data = mem; e.pend = 0; end
            e.age++;
            if (e.age < 3) nq.push_back(e);
        end
        if (fire && wr && rd != 0) nq.push_front('{0, ld, rd, ld ? 32'h0 : res});
        mq    = nq;
        m_lv  = fire && wr && ld && rd != 0;
        m_lrd = rd;
    endtask

    task automatic idle(string tag, int rs1, int rs2, logic [31:0] mem);
        step(tag, 1, rs1, rs2, 0, 0, 0, 32'h0, mem, 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst = 1; flush = 0; ex_valid = 0; ex_rs1 = 0; ex_rs2 = 0; ex_rf1 = 0;
        ex_rf2 = 0; ex_wr_en = 0; ex_is_load = 0; ex_rd = 0; ex_result = 0;
        mem_ld_data = 0; m_lv = 0; m_lrd = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;

        idle("R1 reset passthrough", 5, 6, 32'h0);

        step("R2 write x5", 1, 1, 2, 1, 0, 5, 32'h0000_0011, 32'h0, 0);
        for (int k = 0; k < 3; k++) idle("R2 forward window", 5, 5, 32'h0);
        idle("R2 expired", 5, 5, 32'h0);
        idle("R9 no match", 8, 9, 32'h0);

        step("R3 write x7 A", 1, 1, 2, 1, 0, 7, 32'hAAAA_0001, 32'h0, 0);
        step("R3 write x7 B", 1, 7, 2, 1, 0, 7, 32'hBBBB_0002, 32'h0, 0);
        idle("R3 youngest wins", 7, 7, 32'h0);

        step("R4 write x0", 1, 1, 2, 1, 0, 0, 32'h0000_0099, 32'h0, 0);
        idle("R4 x0 not forwarded", 0, 0, 32'h0);
        step("R4 load x0", 1, 1, 2, 1, 1, 0, 32'h0, 32'h0, 0);
        idle("R4 x0 no stall", 0, 3, 32'h1234_5678);

        step("R5 load x9", 1, 1, 2, 1, 1, 9, 32'h0, 32'h0, 0);
        step("R5 dependent stalls", 1, 1, 9, 1, 0, 12, 32'hC0DE_000C, 32'h0, 0);
        step("R6 retry gets mem data", 1, 1, 9, 1, 0, 12, 32'hC0DE_000C, 32'hD00D_0009, 0);
        idle("R6 captured load data", 9, 12, 32'h5555_5555);

        step("R7 invalid write", 0, 1, 2, 1, 0, 14, 32'h0000_0E14, 32'h0, 0);
        idle("R7 invalid not stored", 14, 14, 32'h0);
        step("R7 flushed write", 1, 1, 2, 1, 0, 15, 32'h0000_0E15, 32'h0, 1);
        idle("R7 flushed not stored", 15, 15, 32'h0);

        step("R8 write x3", 1, 1, 2, 1, 0, 3, 32'h0000_0C03, 32'h0, 0);
        step("R8 load x4", 1, 1, 2, 1, 1, 4, 32'h0, 32'h0, 0);
        step("R8 flush no stall", 1, 4, 4, 0, 0, 0, 32'h0, 32'h0, 1);
        idle("R8 older entries kept", 3, 4, 32'hE0E0_0004);
        idle("R8 after flush", 4, 3, 32'h0);

        step("R10 load x10", 1, 1, 2, 1, 1, 10, 32'h0, 32'h0, 0);
        step("R10 bubble no stall", 0, 10, 10, 0, 0, 0, 32'h0, 32'h0, 0);
        idle("R6 bubble then mem data", 10, 1, 32'hF0F0_0010);

        step("R5 load x11", 1, 1, 2, 1, 1, 11, 32'h0, 32'h0, 0);
        step("R5 rs1 dependent stalls", 1, 11, 2, 0, 0, 0, 32'h0, 32'h0, 0);
        step("R6 rs1 retry", 1, 11, 2, 0, 0, 0, 32'h0, 32'h1111_0011, 0);
        for (int k = 0; k < 3; k++) idle("R2 drain", 11, 9, 32'h0);

        finish_run();
    end

endmodule